// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Access Permissions

This block turns 32-bit virtual addresses into 32-bit physical addresses for a processor that uses 4 KB pages. It holds a parameterised array of translation entries organised as sets and ways. Each entry carries a physical frame number, three separate permission bits (read, write, execute) and a cacheable attribute. A lookup request is taken in on a clock edge, and its result appears on registered outputs one cycle later: the physical address, a miss flag, a permission-fault flag and the cacheable attribute of the page.

System software owns everything around the array. It walks its own page tables and picks the victim way itself. It fills an entry through a write port that names the way, and it can drop single entries or flush the whole array in one cycle. One fixed virtual window, 0xC0000000 to 0xDFFFFFFF, never consults the array. It lands directly on the lowest 512 MB of physical space. A processor uses two instances: one for instruction fetches and one for data accesses.

The control is a two-state machine. In `ST_IDLE` no response is being presented. The transition `IDLE_TO_RESP` is taken on any edge where a lookup is requested. In `ST_RESP` a result is on the outputs. The transition `RESP_TO_RESP` is taken when another lookup follows back to back, and `RESP_TO_IDLE` when no lookup is requested.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup requested with `lk_valid` high at a clock edge raises `rsp_valid` with its result after that edge for one cycle. `rsp_valid` is low after reset and after any edge without a request. Reset leaves every entry invalid.
- R2: For a result that is not a miss, `rsp_paddr[11:0]` equals `lk_vaddr[11:0]` of the request.
- R3: A request whose `lk_vaddr[31:29]` is 3'b110 yields `rsp_paddr` equal to the virtual address with bits 31:29 cleared, with `rsp_miss`=0, `rsp_fault`=0 and `rsp_cache`=0, whatever the array holds.
- R4: Outside the window, the set index is `lk_vaddr[12+IDX_W-1:12]` (IDX_W = log2 SETS) and the tag is the rest of the virtual page number. A valid entry in that set with an equal tag is a hit, and `rsp_paddr[31:12]` is its frame number.
- R5: Outside the window, when no valid entry in the indexed set matches, `rsp_miss`=1 and `rsp_fault`=0. `rsp_paddr` is then undefined.
- R6: Access kind codes are 0 read, 1 write, 2 execute and 3 none. Permission bits are bit0 read, bit1 write and bit2 execute. A hit whose kind lacks its bit (code 3 always lacks it) gives `rsp_fault`=1 and `rsp_miss`=0, and the address is still reported.
- R7: On a hit, `rsp_cache` equals the cacheable bit stored in the matching entry.
- R8: `wr_en` writes the way `wr_way` of the set selected by the low bits of `wr_vpn`, with valid bit `wr_valid`. `wr_valid`=0 invalidates that slot. A lookup on the same edge sees the contents as they were before the write.
- R9: `flush` clears every valid bit on one edge. A write on the same edge is discarded.
- R10: When several ways of a set match, the lowest-numbered way supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| wr_en | input | 1 | Entry write strobe |
| wr_vpn | input | 20 | Virtual page number of the entry (selects set and tag) |
| wr_way | input | log2(WAYS) | Way to write, chosen by software |
| wr_valid | input | 1 | Valid bit written (0 invalidates) |
| wr_pfn | input | 20 | Physical frame number |
| wr_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| wr_cache | input | 1 | Cacheable attribute of the page |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | 32 | Physical address |
| rsp_miss | output | 1 | No translation found |
| rsp_fault | output | 1 | Translation found but access not permitted |
| rsp_cache | output | 1 | Page is cacheable |

## Verification
The bench targets several corner cases. It plants an entry whose page lies inside the fixed window; a design that checks the array first would return that entry's frame instead of the direct mapping. It loads the same tag into two ways; a wrong priority encoder would return the higher way's frame. It puts a write and a lookup, or a write and a flush, on the same edge; a design with write-through forwarding, or with the wrong flush priority, would report a hit where a miss is due. It also probes the access kind that has no permission bit and pages that share a set index but not a tag; a design that compares only part of the tag, or that grants the unused code, would translate instead of missing or faulting.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PAGE_W = 12;
    localparam int VPN_W  = VA_W - PAGE_W;
    localparam logic [2:0] WIN_TOP = 3'b110;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_t;

    typedef struct packed {
        logic [VPN_W-1:0] pfn;
        logic [2:0]       perm;   // bit0 read, bit1 write, bit2 execute
        logic             cache;
    } tlb_payload_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } xl_state_t;
endpackage

// File: rtl/tlb_array.sv
module tlb_array
    import tlb_pkg::*;
#(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int TAG_W = VPN_W - IDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        wr_en,
    input  logic [VPN_W-1:0]            wr_vpn,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic                        wr_valid,
    input  tlb_payload_t                wr_data,
    input  logic [VPN_W-1:0]            rd_vpn,
    output logic [WAYS-1:0]             hit_vec,
    output tlb_payload_t [WAYS-1:0]     rd_data
);
    logic [WAYS-1:0] vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    tlb_payload_t     pay_q [SETS][WAYS];

    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [TAG_W-1:0] wr_tag, rd_tag;

    assign wr_idx = wr_vpn[IDX_W-1:0];
    assign wr_tag = wr_vpn[VPN_W-1:IDX_W];
    assign rd_idx = rd_vpn[IDX_W-1:0];
    assign rd_tag = rd_vpn[VPN_W-1:IDX_W];

    // Valid bits: flush beats a concurrent write.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx][wr_way] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][wr_way] <= wr_tag;
            pay_q[wr_idx][wr_way] <= wr_data;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = vld_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
        assign rd_data[w] = pay_q[rd_idx][w];
    end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
    import tlb_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  logic [VA_W-1:0]         vaddr,
    input  logic [1:0]              kind,
    input  logic [WAYS-1:0]         hit_vec,
    input  tlb_payload_t [WAYS-1:0] way_data,
    output logic [VA_W-1:0]         paddr,
    output logic                    miss,
    output logic                    fault,
    output logic                    cache
);
    tlb_payload_t sel;
    logic         found;
    logic         perm_ok;
    logic         in_win;

    // Lowest way wins: scan downward so the last assignment is the lowest hit.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                sel   = way_data[w];
                found = 1'b1;
            end
        end
    end

    always_comb begin
        unique case (acc_kind_t'(kind))
            ACC_READ:  perm_ok = sel.perm[0];
            ACC_WRITE: perm_ok = sel.perm[1];
            ACC_EXEC:  perm_ok = sel.perm[2];
            ACC_NONE:  perm_ok = 1'b0;
            default:   perm_ok = 1'b0;
        endcase
    end

    assign in_win = (vaddr[VA_W-1:VA_W-3] == WIN_TOP);

    always_comb begin
        if (in_win) begin
            paddr = {3'b000, vaddr[VA_W-4:0]};
            miss  = 1'b0;
            fault = 1'b0;
            cache = 1'b0;
        end else begin
            paddr = {sel.pfn, vaddr[PAGE_W-1:0]};
            miss  = !found;
            fault = found && !perm_ok;
            cache = found && sel.cache;
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [31:0]      lk_vaddr,
    input  logic [1:0]       lk_kind,
    input  logic             wr_en,
    input  logic [19:0]      wr_vpn,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             wr_valid,
    input  logic [19:0]      wr_pfn,
    input  logic [2:0]       wr_perm,
    input  logic             wr_cache,
    input  logic             flush,
    output logic             rsp_valid,
    output logic [31:0]      rsp_paddr,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic             rsp_cache
);
    xl_state_t state_q, state_d;

    logic [WAYS-1:0]         hit_vec;
    tlb_payload_t [WAYS-1:0] way_data;
    tlb_payload_t            wr_data;
    logic [31:0]             res_paddr;
    logic                    res_miss, res_fault, res_cache;

    assign wr_data = '{pfn: wr_pfn, perm: wr_perm, cache: wr_cache};

    tlb_array #(.SETS(SETS), .WAYS(WAYS)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_vpn   (wr_vpn),
        .wr_way   (wr_way),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_vpn   (lk_vaddr[31:12]),
        .hit_vec  (hit_vec),
        .rd_data  (way_data)
    );

    tlb_resolve #(.WAYS(WAYS)) u_resolve (
        .vaddr    (lk_vaddr),
        .kind     (lk_kind),
        .hit_vec  (hit_vec),
        .way_data (way_data),
        .paddr    (res_paddr),
        .miss     (res_miss),
        .fault    (res_fault),
        .cache    (res_cache)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (lk_valid) state_d = ST_RESP;   // IDLE_TO_RESP
            ST_RESP: state_d = lk_valid ? ST_RESP       // RESP_TO_RESP
                                        : ST_IDLE;      // RESP_TO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_paddr <= '0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cache <= 1'b0;
        end else if (lk_valid) begin
            rsp_paddr <= res_paddr;
            rsp_miss  <= res_miss;
            rsp_fault <= res_fault;
            rsp_cache <= res_cache;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [31:0] lk_vaddr,
    input logic        flush,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic        rsp_miss,
    input logic        rsp_fault
);
    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_miss || rsp_paddr[11:0] == $past(lk_vaddr[11:0])));

    assert_window_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_vaddr[31:29] == 3'b110) |=>
            (!rsp_miss && !rsp_fault && rsp_paddr == {3'b000, $past(lk_vaddr[28:0])}));

    assert_miss_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_miss && rsp_fault));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && lk_valid && lk_vaddr[31:29] != 3'b110) |=> rsp_miss);
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault)
);

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;
    localparam int SETS = 16;
    localparam int WAYS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_kind = '0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_vpn = '0;
    logic [1:0]  wr_way = '0;
    logic        wr_valid = 1'b0;
    logic [19:0] wr_pfn = '0;
    logic [2:0]  wr_perm = '0;
    logic        wr_cache = 1'b0;
    logic        flush = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_miss, rsp_fault, rsp_cache;

    always #2.5 clk = ~clk;

    tlb_xlate #(.SETS(SETS), .WAYS(WAYS)) dut (.*);

    // Reference model of the array
    bit          m_vld  [SETS][WAYS];
    logic [19:0] m_vpn  [SETS][WAYS];
    logic [19:0] m_pfn  [SETS][WAYS];
    logic [2:0]  m_perm [SETS][WAYS];
    bit          m_cache[SETS][WAYS];

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Returns {miss, fault, cache, paddr}
    function automatic logic [34:0] model_xlate(input logic [31:0] va, input logic [1:0] kind);
        logic [19:0] vpn;
        int          s;
        bit          ok;
        vpn = va[31:12];
        s   = int'(vpn[3:0]);
        if (va[31:29] == 3'b110) return {3'b000, 3'b000, va[28:0]};
        for (int w = 0; w < WAYS; w++) begin
            if (m_vld[s][w] && m_vpn[s][w] == vpn) begin
                ok = (kind == 2'd3) ? 1'b0 : m_perm[s][w][kind];
                return {1'b0, !ok, m_cache[s][w], m_pfn[s][w], va[11:0]};
            end
        end
        return {3'b100, 32'h0};
    endfunction

    task automatic set_lookup(input logic [31:0] va, input logic [1:0] kind);
        lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind;
    endtask

    task automatic set_write(input logic [19:0] vpn, input logic [1:0] way, input logic [19:0] pfn,
                             input logic [2:0] perm, input logic cch, input logic v);
        wr_en = 1'b1; wr_vpn = vpn; wr_way = way; wr_pfn = pfn;
        wr_perm = perm; wr_cache = cch; wr_valid = v;
    endtask

    // One edge: expected values from the model state before the edge.
    task automatic cycle(input string req);
        logic [34:0] exp;
        bit          look;
        look = lk_valid;
        exp  = model_xlate(lk_vaddr, lk_kind);
        @(posedge clk);
        if (flush) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) m_vld[s][w] = 1'b0;
        end else if (wr_en) begin
            m_vld  [wr_vpn[3:0]][wr_way] = wr_valid;
            m_vpn  [wr_vpn[3:0]][wr_way] = wr_vpn;
            m_pfn  [wr_vpn[3:0]][wr_way] = wr_pfn;
            m_perm [wr_vpn[3:0]][wr_way] = wr_perm;
            m_cache[wr_vpn[3:0]][wr_way] = wr_cache;
        end
        @(negedge clk);
        if (look) begin
            chk({req, " R1 valid"}, {31'b0, rsp_valid}, 32'd1);
            chk({req, " flags"}, {29'b0, rsp_miss, rsp_fault, rsp_cache}, {29'b0, exp[34:32]});
            if (!exp[34]) chk({req, " paddr"}, rsp_paddr, exp[31:0]);
        end
        lk_valid = 1'b0; wr_en = 1'b0; flush = 1'b0;
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        report();
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_vld[s][w] = 1'b0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid low", {31'b0, rsp_valid}, 32'd0);

        set_lookup(32'h0000_5123, 2'd0);          cycle("R5 empty after reset");
        set_lookup(32'hC000_1234, 2'd2);          cycle("R3 window low edge");
        set_lookup(32'hDFFF_FFFF, 2'd1);          cycle("R3 window high edge");
        chk("R3 window paddr", rsp_paddr, 32'h1FFF_FFFF);

        set_write(20'h00123, 2'd2, 20'hABCDE, 3'b001, 1'b1, 1'b1); cycle("R8 load");
        set_lookup(32'h0012_3456, 2'd0);          cycle("R4 R7 read hit");
        chk("R4 hit paddr", rsp_paddr, 32'hABCD_E456);
        chk("R7 cacheable", {31'b0, rsp_cache}, 32'd1);
        set_lookup(32'h0012_3456, 2'd1);          cycle("R6 write denied");
        chk("R6 fault flag", {30'b0, rsp_fault, rsp_miss}, 32'd2);
        set_lookup(32'h0012_3000, 2'd2);          cycle("R6 exec denied");
        set_lookup(32'h0012_3000, 2'd3);          cycle("R6 kind none");
        set_lookup(32'h0013_3000, 2'd0);          cycle("R4 same set other tag");

        set_write(20'h00123, 2'd3, 20'h55555, 3'b111, 1'b0, 1'b1); cycle("R8 load");
        set_write(20'h00123, 2'd1, 20'h22222, 3'b111, 1'b0, 1'b1); cycle("R8 load");
        set_lookup(32'h0012_3ABC, 2'd1);          cycle("R10 lowest way");
        chk("R10 frame", rsp_paddr, 32'h2222_2ABC);

        set_write(20'hC0005, 2'd0, 20'h33333, 3'b000, 1'b1, 1'b1); cycle("R8 load");
        set_lookup(32'hC000_5010, 2'd0);          cycle("R3 window ignores entry");
        chk("R3 bypass despite entry", rsp_paddr, 32'h0000_5010);

        set_write(20'h00123, 2'd1, 20'h22222, 3'b111, 1'b0, 1'b0); cycle("R8 invalidate");
        set_lookup(32'h0012_3004, 2'd0);          cycle("R8 next way after invalidate");
        chk("R8 frame after invalidate", rsp_paddr, 32'hABCD_E004);

        set_write(20'h00777, 2'd0, 20'h44444, 3'b111, 1'b1, 1'b1);
        set_lookup(32'h0077_7000, 2'd0);          cycle("R8 same-edge write unseen");
        chk("R8 same-edge miss", {31'b0, rsp_miss}, 32'd1);
        set_lookup(32'h0077_7000, 2'd0);          cycle("R8 write then seen");

        flush = 1'b1;
        set_write(20'h00888, 2'd0, 20'h66666, 3'b111, 1'b1, 1'b1); cycle("R9 flush with write");
        set_lookup(32'h0088_8000, 2'd0);          cycle("R9 write discarded");
        set_lookup(32'h0012_3456, 2'd0);          cycle("R9 flushed");
        @(negedge clk);
        chk("R1 idle valid low", {31'b0, rsp_valid}, 32'd0);

        for (int i = 0; i < 600; i++) begin
            int r;
            logic [19:0] vpn;
            r = $urandom_range(0, 99);
            vpn = (r % 3 == 0) ? 20'($urandom) : {16'($urandom_range(0, 5)), 4'($urandom_range(0, 15))};
            if (r < 2) begin
                flush = 1'b1;
                cycle("R9 random flush");
            end else if (r < 40) begin
                set_write(vpn, 2'($urandom), 20'($urandom), 3'($urandom), 1'($urandom),
                          ($urandom_range(0, 7) != 0));
                if (r < 10) set_lookup({vpn, 12'($urandom)}, 2'($urandom));
                cycle("R8 random write");
            end else begin
                set_lookup({vpn, 12'($urandom)}, 2'($urandom));
                cycle("R4 R6 random lookup");
            end
        end

        report();
    end
endmodule